// File: doc/BRIEF.md
# Packed Multiply-Add Dot-Product Engine

This unit computes the dot product of two signed 16-bit vectors. Software or a feeding datapath starts a job by giving an element count and a final shift amount, then streams operand pairs: each pair is two 64-bit words, and each word carries four signed 16-bit elements. For every accepted pair the unit forms four signed products. The two products of the upper element pair go into one 32-bit sum and the two of the lower pair into another. These two sums enter a packed accumulator of two independent 32-bit lanes.

When the last step of a job has been added, the two accumulator lanes are summed into one 32-bit scalar. That scalar is shifted right arithmetically by the amount given at start, which restores a fixed-point scale after the multiplies. The scalar appears on the result port together with a one-cycle done pulse. The multiply-add step and the accumulate step sit in consecutive pipeline stages, so an eight-element product takes two multiply-add steps and two accumulate steps. Fetching operands and detecting overflow are left to the surrounding logic, and all arithmetic wraps at 32 bits.

Top module: `pmd_dot_engine`

## Requirements
- R1: Element k of an operand word occupies bits [16k+15:16k]. Each accepted step multiplies the signed elements pairwise. Products of elements 3 and 2 are summed into the upper lane and those of elements 1 and 0 into the lower lane, with each product and sum wrapping at 32 bits.
- R2: A job's accumulator lanes start at zero, and each step's two lane sums are added into them, wrapping at 32 bits. Asserting start_i clears both lanes.
- R3: A job runs len_i/4 steps; the two low bits of len_i are ignored. While steps remain, one operand pair is accepted on each rising edge where op_valid_i is high, and cycles without op_valid_i are allowed between steps.
- R4: result_o equals (upper lane + lower lane, wrapping at 32 bits) arithmetically shifted right by the shift_i value captured at start. It is valid while done_o is high.
- R5: done_o is high for exactly one cycle per completed job, after the second rising edge that follows the edge accepting the last step. result_o keeps its value until the next done pulse.
- R6: A start with fewer than 4 elements issues done_o after the edge following the start edge, with result_o equal to 0.
- R7: start_i outranks op_valid_i: an operand offered in a start cycle is not accepted. A start while steps of a job remain abandons that job, so no done_o is given for it. A start in a cycle where done_o is high leaves that pulse and its result unchanged, and the new job runs normally.
- R8: op_valid_i outside a job has no effect: done_o stays low and result_o keeps its value.
- R9: While the reset is asserted, and after it is released, done_o is 0 and result_o is 0 until the first job completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Begin a new job, clearing the accumulator |
| len_i | input | 16 | Element count of the job (multiple of 4) |
| shift_i | input | 5 | Arithmetic right shift applied to the final scalar |
| op_valid_i | input | 1 | Operand pair present on op_a_i and op_b_i |
| op_a_i | input | 64 | Four signed 16-bit elements of vector A |
| op_b_i | input | 64 | Four signed 16-bit elements of vector B |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 32 | Shifted dot product, held until the next completion |

## Verification
The collision that matters is a new start arriving in the very cycle the previous job's done pulse is on the ports. The start clears the accumulator and reloads the step counter and shift. The registered completion of the old job must still show its own result, computed with its own shift. The bench provokes this by raising start_i and presenting the next job's parameters during the done cycle of a job. In that cycle it checks that done_o is high and that result_o carries the old job's value. The new job then receives its operands, and its result must match a model that sees only the new job's operands and shift, which shows that nothing leaked across the boundary.

// File: rtl/pmd_pkg.sv
package pmd_pkg;
  localparam int ELEM_W    = 16;
  localparam int ELEMS     = 4;
  localparam int PAIRS     = ELEMS / 2;
  localparam int LOG_ELEMS = $clog2(ELEMS);
  localparam int SUM_W     = 2 * ELEM_W;
  localparam int OP_W      = ELEMS * ELEM_W;
  localparam int SH_W      = $clog2(SUM_W);
  localparam int CNT_W     = 16;

  typedef logic [PAIRS-1:0][SUM_W-1:0] lanes_t;
endpackage

// File: rtl/pmd_rst_sync.sv
module pmd_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_no = sync_q[1];
endmodule

// File: rtl/pmd_madd.sv
module pmd_madd
  import pmd_pkg::*;
(
  input  logic [OP_W-1:0] a_i,
  input  logic [OP_W-1:0] b_i,
  output lanes_t          sums_o
);
  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    logic signed [SUM_W-1:0] a_lo, b_lo, a_hi, b_hi;
    logic signed [SUM_W-1:0] prod_lo, prod_hi;

    assign a_lo = SUM_W'($signed(a_i[(2*p)*ELEM_W +: ELEM_W]));
    assign b_lo = SUM_W'($signed(b_i[(2*p)*ELEM_W +: ELEM_W]));
    assign a_hi = SUM_W'($signed(a_i[(2*p+1)*ELEM_W +: ELEM_W]));
    assign b_hi = SUM_W'($signed(b_i[(2*p+1)*ELEM_W +: ELEM_W]));

    assign prod_lo = a_lo * b_lo;
    assign prod_hi = a_hi * b_hi;
    assign sums_o[p] = prod_lo + prod_hi;
  end
endmodule

// File: rtl/pmd_ctrl.sv
module pmd_ctrl
  import pmd_pkg::*;
#(
  parameter int STEPS_W = CNT_W - LOG_ELEMS
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [CNT_W-1:0]   len_i,
  input  logic [SH_W-1:0]    shift_i,
  input  logic               op_valid_i,
  output logic               busy_o,
  output logic [STEPS_W-1:0] left_o,
  output logic [SH_W-1:0]    shift_o,
  output logic               fire_o,
  output logic               last_o,
  output logic               zero_o
);
  logic               busy_q, busy_d;
  logic [STEPS_W-1:0] left_q, left_d;
  logic [SH_W-1:0]    sh_q;
  logic [STEPS_W-1:0] steps;
  logic               left_en;
  logic [LOG_ELEMS-1:0] unused_len_lo;

  assign steps         = len_i[CNT_W-1:LOG_ELEMS];
  assign unused_len_lo = len_i[LOG_ELEMS-1:0];

  assign fire_o = busy_q & op_valid_i & ~start_i;
  assign last_o = fire_o & (left_q == STEPS_W'(1));
  assign zero_o = (steps == '0);

  always_comb begin
    busy_d  = busy_q;
    left_d  = left_q;
    left_en = 1'b0;
    if (start_i) begin
      busy_d  = ~zero_o;
      left_d  = steps;
      left_en = 1'b1;
    end else if (fire_o) begin
      left_d  = left_q - STEPS_W'(1);
      left_en = 1'b1;
      if (last_o) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      left_q <= '0;
      sh_q   <= '0;
    end else begin
      busy_q <= busy_d;
      if (left_en) left_q <= left_d;
      if (start_i) sh_q   <= shift_i;
    end
  end

  assign busy_o  = busy_q;
  assign left_o  = left_q;
  assign shift_o = sh_q;
endmodule

// File: rtl/pmd_accum.sv
module pmd_accum
  import pmd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             zero_i,
  input  logic             fire_i,
  input  logic             last_i,
  input  lanes_t           sums_i,
  input  logic [SH_W-1:0]  shift_i,
  output lanes_t           acc_o,
  output logic             pv_o,
  output logic             done_o,
  output logic [SUM_W-1:0] result_o
);
  lanes_t           psum_q, acc_q, acc_d;
  logic             pv_q, plast_q, pv_d;
  logic             fin_q, fin_d;
  logic             done_q;
  logic [SUM_W-1:0] res_q, res_d, total;

  always_comb begin
    pv_d  = start_i ? 1'b0 : fire_i;
    fin_d = start_i ? zero_i : (pv_q & plast_q);
  end

  for (genvar p = 0; p < PAIRS; p++) begin : g_lane
    always_comb begin
      if (start_i)   acc_d[p] = '0;
      else if (pv_q) acc_d[p] = acc_q[p] + psum_q[p];
      else           acc_d[p] = acc_q[p];
    end
  end

  always_comb begin
    total = '0;
    for (int p = 0; p < PAIRS; p++) total = total + acc_q[p];
    res_d = SUM_W'($signed(total) >>> shift_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psum_q  <= '0;
      pv_q    <= 1'b0;
      plast_q <= 1'b0;
      acc_q   <= '0;
      fin_q   <= 1'b0;
      done_q  <= 1'b0;
      res_q   <= '0;
    end else begin
      pv_q    <= pv_d;
      plast_q <= last_i;
      if (fire_i) psum_q <= sums_i;
      acc_q   <= acc_d;
      fin_q   <= fin_d;
      done_q  <= fin_q;
      if (fin_q) res_q <= res_d;
    end
  end

  assign acc_o    = acc_q;
  assign pv_o     = pv_q;
  assign done_o   = done_q;
  assign result_o = res_q;
endmodule

// File: rtl/pmd_dot_engine.sv
module pmd_dot_engine
  import pmd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic [SH_W-1:0]  shift_i,
  input  logic             op_valid_i,
  input  logic [OP_W-1:0]  op_a_i,
  input  logic [OP_W-1:0]  op_b_i,
  output logic             done_o,
  output logic [SUM_W-1:0] result_o
);
  localparam int STEPS_W = CNT_W - LOG_ELEMS;

  logic               rst_sync_n;
  logic               busy_w, fire_w, last_w, zero_w, pv_w;
  logic [STEPS_W-1:0] left_w;
  logic [SH_W-1:0]    sh_w;
  lanes_t             sums_w, acc_w;

  pmd_rst_sync u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  pmd_ctrl #(.STEPS_W(STEPS_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .start_i    (start_i),
    .len_i      (len_i),
    .shift_i    (shift_i),
    .op_valid_i (op_valid_i),
    .busy_o     (busy_w),
    .left_o     (left_w),
    .shift_o    (sh_w),
    .fire_o     (fire_w),
    .last_o     (last_w),
    .zero_o     (zero_w)
  );

  pmd_madd u_madd (
    .a_i    (op_a_i),
    .b_i    (op_b_i),
    .sums_o (sums_w)
  );

  pmd_accum u_acc (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_n),
    .start_i  (start_i),
    .zero_i   (zero_w),
    .fire_i   (fire_w),
    .last_i   (last_w),
    .sums_i   (sums_w),
    .shift_i  (sh_w),
    .acc_o    (acc_w),
    .pv_o     (pv_w),
    .done_o   (done_o),
    .result_o (result_o)
  );
endmodule

// File: rtl/pmd_chk.sv
module pmd_chk
  import pmd_pkg::*;
#(
  parameter int STEPS_W = CNT_W - LOG_ELEMS
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   start_i,
  input logic [CNT_W-1:0]       len_i,
  input logic                   done_o,
  input logic [SUM_W-1:0]       result_o,
  input logic                   busy,
  input logic [STEPS_W-1:0]     left,
  input logic                   pv,
  input logic [PAIRS*SUM_W-1:0] acc
);
  // R3: a running job always has steps left
  a_r3_busy_has_steps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> (left != '0));

  // R2: start empties both lanes
  a_r2_start_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (acc == '0));

  // R7: an operand offered with start never enters the pipeline
  a_r7_start_blocks_op: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !pv);

  // R6: a job without full steps finishes one edge later
  a_r6_zero_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && (len_i[CNT_W-1:LOG_ELEMS] == '0)) |=> (!busy ##1 done_o));

  // R8: idle accumulator does not move
  a_r8_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && !pv && !start_i) |=> $stable(acc));

  // R5: result only changes together with a done pulse
  a_r5_result_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(result_o));
endmodule

bind pmd_dot_engine pmd_chk #(.STEPS_W(STEPS_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .len_i    (len_i),
  .done_o   (done_o),
  .result_o (result_o),
  .busy     (busy_w),
  .left     (left_w),
  .pv       (pv_w),
  .acc      (acc_w)
);

// File: tb/tb_pmd_dot_engine.sv
module tb_pmd_dot_engine;
  logic        clk;
  logic        rst_n;
  logic        start;
  logic [15:0] len;
  logic [4:0]  shift;
  logic        op_valid;
  logic [63:0] op_a, op_b;
  logic        done;
  logic [31:0] result;

  int checks = 0;
  int errors = 0;

  typedef struct packed {
    logic [63:0] a0, b0, a1, b1;
    logic [4:0]  sh;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{64'h0001_0002_0003_0004, 64'h0005_0006_0007_0008,
      64'h0001_0001_0001_0001, 64'h0001_0001_0001_0001, 5'd0},
    '{64'hFFFF_FFFE_0010_8000, 64'h0003_0004_FFF0_0002,
      64'h7FFF_7FFF_7FFF_7FFF, 64'h7FFF_7FFF_8001_8001, 5'd0},
    '{64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000,
      64'h0000_0000_0000_0010, 64'h0000_0000_0000_0003, 5'd0},
    '{64'h0100_0100_0100_0100, 64'h0100_0100_0100_0100,
      64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000, 5'd8},
    '{64'hFF00_0000_0000_0000, 64'h0100_0000_0000_0000,
      64'h0000_0000_0000_0001, 64'h0000_0000_0000_0003, 5'd4},
    '{64'h7FFF_7FFF_7FFF_7FFF, 64'h7FFF_7FFF_7FFF_7FFF,
      64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000, 5'd31}
  };

  pmd_dot_engine dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .start_i    (start),
    .len_i      (len),
    .shift_i    (shift),
    .op_valid_i (op_valid),
    .op_a_i     (op_a),
    .op_b_i     (op_b),
    .done_o     (done),
    .result_o   (result)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [31:0] dot4(input logic [63:0] a, input logic [63:0] b);
    logic [31:0] s = '0;
    for (int k = 0; k < 4; k++)
      s = s + 32'($signed(a[16*k +: 16]) * $signed(b[16*k +: 16]));
    return s;
  endfunction

  function automatic logic [31:0] scale(input logic [31:0] v, input logic [4:0] sh);
    return 32'($signed(v) >>> sh);
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic start_job(input logic [15:0] l, input logic [4:0] s);
    @(negedge clk);
    start = 1'b1; len = l; shift = s; op_valid = 1'b0;
  endtask

  task automatic step(input logic [63:0] a, input logic [63:0] b);
    @(negedge clk);
    start = 1'b0; op_valid = 1'b1; op_a = a; op_b = b;
  endtask

  task automatic idle();
    @(negedge clk);
    start = 1'b0; op_valid = 1'b0;
  endtask

  // called right after idle() following the last step
  task automatic expect_done(input logic [31:0] exp, input string tag);
    chk(done == 1'b0, {tag, " R5 early0"}, 32'(done), 32'd0);
    @(negedge clk);
    chk(done == 1'b0, {tag, " R5 early1"}, 32'(done), 32'd0);
    @(negedge clk);
    chk(done == 1'b1, {tag, " R5 pulse"}, 32'(done), 32'd1);
    chk(result == exp, {tag, " R4 value"}, result, exp);
    @(negedge clk);
    chk(done == 1'b0, {tag, " R5 single"}, 32'(done), 32'd0);
    chk(result == exp, {tag, " R5 hold"}, result, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] exp, exp_b;
    rst_n = 1'b0; start = 1'b0; len = '0; shift = '0;
    op_valid = 1'b0; op_a = '0; op_b = '0;
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R9 done in reset", 32'(done), 32'd0);
    chk(result == 32'd0, "R9 result in reset", result, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(done == 1'b0, "R9 done after reset", 32'(done), 32'd0);
    chk(result == 32'd0, "R9 result after reset", result, 32'd0);

    // R1 R2 R4: table of eight-element jobs
    for (int i = 0; i < 6; i++) begin
      exp = scale(dot4(VEC[i].a0, VEC[i].b0) + dot4(VEC[i].a1, VEC[i].b1), VEC[i].sh);
      start_job(16'd8, VEC[i].sh);
      step(VEC[i].a0, VEC[i].b0);
      step(VEC[i].a1, VEC[i].b1);
      idle();
      expect_done(exp, $sformatf("R1 R2 vec%0d", i));
    end

    // R3: twelve elements with gaps, low len bits set and ignored
    exp = dot4(64'h0002_0002_0002_0002, 64'h0003_0003_0003_0003)
        + dot4(64'hFFFF_0001_FFFF_0001, 64'h0004_0004_0004_0004)
        + dot4(64'h0000_0000_0000_0005, 64'h0000_0000_0000_0007);
    start_job(16'd15, 5'd0);
    step(64'h0002_0002_0002_0002, 64'h0003_0003_0003_0003);
    idle();
    chk(done == 1'b0, "R3 gap no done", 32'(done), 32'd0);
    step(64'hFFFF_0001_FFFF_0001, 64'h0004_0004_0004_0004);
    idle(); idle();
    step(64'h0000_0000_0000_0005, 64'h0000_0000_0000_0007);
    idle();
    expect_done(exp, "R3 gaps");

    // R8: operands while idle
    exp = result;
    for (int i = 0; i < 4; i++) begin
      step(64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321);
      chk(done == 1'b0, "R8 idle done", 32'(done), 32'd0);
      chk(result == exp, "R8 idle result", result, exp);
    end
    idle(); idle();
    chk(done == 1'b0, "R8 idle done late", 32'(done), 32'd0);
    chk(result == exp, "R8 idle result late", result, exp);

    // R6: fewer than four elements
    start_job(16'd2, 5'd3);
    idle();
    chk(done == 1'b0, "R6 not yet", 32'(done), 32'd0);
    @(negedge clk);
    chk(done == 1'b1, "R6 done", 32'(done), 32'd1);
    chk(result == 32'd0, "R6 zero result", result, 32'd0);
    @(negedge clk);
    chk(done == 1'b0, "R6 single", 32'(done), 32'd0);

    // R7: operand offered in the start cycle is dropped
    exp = dot4(64'h0000_0003_0000_0002, 64'h0000_0005_0000_0004);
    @(negedge clk);
    start = 1'b1; len = 16'd4; shift = 5'd0;
    op_valid = 1'b1; op_a = 64'h7FFF_7FFF_7FFF_7FFF; op_b = 64'h7FFF_7FFF_7FFF_7FFF;
    step(64'h0000_0003_0000_0002, 64'h0000_0005_0000_0004);
    idle();
    expect_done(exp, "R7 start beats op");

    // R7: restart while steps remain abandons the old job
    exp = scale(dot4(64'hFFF0_0000_0000_0000, 64'h0010_0000_0000_0000), 5'd1);
    start_job(16'd8, 5'd0);
    step(64'h0100_0100_0100_0100, 64'h0100_0100_0100_0100);
    start_job(16'd4, 5'd1);
    step(64'hFFF0_0000_0000_0000, 64'h0010_0000_0000_0000);
    idle();
    expect_done(exp, "R7 abandon");
    idle(); idle();
    chk(done == 1'b0, "R7 no stale done", 32'(done), 32'd0);

    // R7: new start in the cycle of the done pulse
    exp   = scale(dot4(64'h0010_0020_0030_0040, 64'h0001_0001_0001_0001), 5'd2);
    exp_b = scale(dot4(64'h0001_0000_0000_0000, 64'h0009_0000_0000_0000)
                + dot4(64'h0000_0000_0000_FFFE, 64'h0000_0000_0000_0003), 5'd0);
    start_job(16'd4, 5'd2);
    step(64'h0010_0020_0030_0040, 64'h0001_0001_0001_0001);
    idle();
    @(negedge clk);
    @(negedge clk);
    start = 1'b1; len = 16'd8; shift = 5'd0;
    chk(done == 1'b1, "R7 collide pulse", 32'(done), 32'd1);
    chk(result == exp, "R7 collide old result", result, exp);
    step(64'h0001_0000_0000_0000, 64'h0009_0000_0000_0000);
    step(64'h0000_0000_0000_FFFE, 64'h0000_0000_0000_0003);
    idle();
    expect_done(exp_b, "R7 collide new job");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule